// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the control and status flags for the default control endpoint of a USB device controller running in peripheral mode. Firmware talks to it through a 16-bit register port: a write strobe with write data carries commands, and the read data shows the current flags at all times. The packet engine on the link side reports four events: a packet arrived, a loaded packet went out, a STALL handshake was sent, and a control transfer finished.

The block turns these events and commands into several outputs. Two of them are held levels: a transmit-ready level for the transmitter and a STALL request for the link. The others are single-cycle pulses, all registered: a FIFO discard request, a FIFO pointer reset and an interrupt pulse. Status flags never clear through a plain write of 0. They clear only through dedicated write-one command bits or through link events. A discard command is ignored unless a packet-ready flag is up.

Top module: `ep0_ctl_status`

## Requirements
- R1: After reset every flag, pulse and level output is 0. Read-data bits 15..9, 8 (flush), 7 and 6 (service commands) always read 0.
- R2: A write with bit 8 set while tx-ready (bit 1) or rx-ready (bit 0) is 1 clears both ready flags. It also makes `fifo_flush` and `fifo_ptr_rst` high for exactly the one cycle after the write.
- R3: A write with bit 8 set while both ready flags are 0 changes no flag and produces no flush pulse.
- R4: Writing 1 to bit 7 clears setup-end (bit 4). Writing 1 to bit 6 clears rx-ready (bit 0). Writing 0 to bit 7 or bit 6 does nothing.
- R5: Writing 1 to bit 5 sets the stall flag, which drives `stall_req`. The flag stays set until `lnk_stall_sent` and clears on the edge where `lnk_stall_sent` is high.
- R6: `lnk_stall_sent` sets sent-stall (bit 2). A write with bit 2 = 1 clears it. A write with bit 2 = 0 leaves it unchanged.
- R7: `lnk_xfer_end` while data-end (bit 3) is 0 does three things. It sets setup-end. It makes the FIFO discard and pointer-reset pulses high for one cycle. It clears both ready flags. When data-end is 1, the event only clears data-end.
- R8: Writing 1 to bit 3 sets data-end. Only `lnk_xfer_end` clears it.
- R9: Writing 1 to bit 1 sets tx-ready, which drives `tx_ready`. `lnk_tx_done` while tx-ready is 1 clears it and counts as an interrupt source.
- R10: `lnk_rx_done` sets rx-ready and counts as an interrupt source. Writing bit 0 has no effect.
- R11: `irq` is high for one cycle, one cycle after a cycle that had an interrupt source (R7, R9, R10) while `irq_en` was 1. It stays low when `irq_en` was 0.
- R12: When a link event and a software command act on the same flag in the same cycle, the link event decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data |
| irq_en | input | 1 | Interrupt enable |
| lnk_rx_done | input | 1 | Packet received event |
| lnk_tx_done | input | 1 | Packet transmitted event |
| lnk_stall_sent | input | 1 | STALL handshake sent event |
| lnk_xfer_end | input | 1 | Control transfer ended event |
| stall_req | output | 1 | STALL request level to the link |
| tx_ready | output | 1 | Transmit packet ready level |
| fifo_flush | output | 1 | FIFO packet discard pulse |
| fifo_ptr_rst | output | 1 | FIFO pointer reset pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench targets same-cycle collisions between link events and commands. One is a received packet arriving in the same cycle as the rx-service write. Another is a STALL being sent while firmware clears sent-stall. A design where the command wins would lose a packet or a STALL report. The bench issues flush commands with no packet pending: a design that forgets the guard emits a spurious discard pulse. It ends transfers both with data-end set and with it clear: a wrong design either raises a false setup-end or misses a real one. It also sends transmit-done with no packet loaded and toggles the interrupt enable around events: errors there show up as stray or missing `irq` pulses.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int CSR_W       = 16;
  localparam int B_FLUSH     = 8;
  localparam int B_SVC_SE    = 7;
  localparam int B_SVC_RX    = 6;
  localparam int B_STALL     = 5;
  localparam int B_SETUPEND  = 4;
  localparam int B_DATAEND   = 3;
  localparam int B_SENTSTALL = 2;
  localparam int B_TXRDY     = 1;
  localparam int B_RXRDY     = 0;

  typedef struct packed {
    logic flush;
    logic svc_setup;
    logic svc_rx;
    logic stall;
    logic dataend;
    logic clr_sent;
    logic txrdy;
  } cmd_t;

  typedef struct packed {
    logic stall;
    logic setupend;
    logic dataend;
    logic sentstall;
    logic txrdy;
    logic rxrdy;
  } flags_t;
endpackage

// File: rtl/ep0_cmd_decode.sv
module ep0_cmd_decode
  import ep0_csr_pkg::*;
#(
  parameter int W = CSR_W
) (
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output cmd_t         cmd
);
  logic unused_bits;
  assign unused_bits = ^{wdata[W-1:B_FLUSH+1], wdata[B_SETUPEND], wdata[B_RXRDY]};

  always_comb begin
    cmd.flush     = wr & wdata[B_FLUSH];
    cmd.svc_setup = wr & wdata[B_SVC_SE];
    cmd.svc_rx    = wr & wdata[B_SVC_RX];
    cmd.stall     = wr & wdata[B_STALL];
    cmd.dataend   = wr & wdata[B_DATAEND];
    cmd.clr_sent  = wr & wdata[B_SENTSTALL];
    cmd.txrdy     = wr & wdata[B_TXRDY];
  end
endmodule

// File: rtl/ep0_flag_regs.sv
module ep0_flag_regs
  import ep0_csr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cmd_t   cmd,
  input  logic   lnk_rx_done,
  input  logic   lnk_tx_done,
  input  logic   lnk_stall_sent,
  input  logic   lnk_xfer_end,
  output flags_t q,
  output logic   irq_src,
  output logic   flush_src
);
  flags_t d;
  logic   flush_hit, setup_hit, tx_hit, upd;

  always_comb begin
    flush_hit = cmd.flush & (q.txrdy | q.rxrdy);
    setup_hit = lnk_xfer_end & ~q.dataend;
    tx_hit    = lnk_tx_done & q.txrdy;
    d = q;
    // software actions first, link actions override
    if (cmd.txrdy) d.txrdy = 1'b1;
    if (tx_hit | flush_hit | setup_hit) d.txrdy = 1'b0;
    if (cmd.svc_rx | flush_hit | setup_hit) d.rxrdy = 1'b0;
    if (lnk_rx_done) d.rxrdy = 1'b1;
    if (cmd.dataend) d.dataend = 1'b1;
    if (lnk_xfer_end) d.dataend = 1'b0;
    if (cmd.svc_setup) d.setupend = 1'b0;
    if (setup_hit) d.setupend = 1'b1;
    if (cmd.stall) d.stall = 1'b1;
    if (lnk_stall_sent) d.stall = 1'b0;
    if (cmd.clr_sent) d.sentstall = 1'b0;
    if (lnk_stall_sent) d.sentstall = 1'b1;
    irq_src   = lnk_rx_done | tx_hit | setup_hit;
    flush_src = flush_hit | setup_hit;
    upd = (|cmd) | lnk_rx_done | lnk_tx_done | lnk_stall_sent | lnk_xfer_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  // R10
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_rx_done |=> q.rxrdy);
  // R6
  sent_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_stall_sent |=> q.sentstall);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q.stall && !lnk_stall_sent) |=> q.stall);
  // R8
  dataend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q.dataend && !lnk_xfer_end) |=> q.dataend);
endmodule

// File: rtl/ep0_pulse_out.sv
module ep0_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic irq_src,
  input  logic flush_src,
  output logic irq,
  output logic fifo_flush,
  output logic fifo_ptr_rst
);
  logic irq_d, flush_d;

  always_comb begin
    irq_d   = irq_en & irq_src;
    flush_d = flush_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq          <= 1'b0;
      fifo_flush   <= 1'b0;
      fifo_ptr_rst <= 1'b0;
    end else begin
      irq          <= irq_d;
      fifo_flush   <= flush_d;
      fifo_ptr_rst <= flush_d;
    end
  end

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
  import ep0_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [CSR_W-1:0] cpu_wdata,
  output logic [CSR_W-1:0] cpu_rdata,
  input  logic             irq_en,
  input  logic             lnk_rx_done,
  input  logic             lnk_tx_done,
  input  logic             lnk_stall_sent,
  input  logic             lnk_xfer_end,
  output logic             stall_req,
  output logic             tx_ready,
  output logic             fifo_flush,
  output logic             fifo_ptr_rst,
  output logic             irq
);
  cmd_t   cmd;
  flags_t flg;
  logic   irq_src, flush_src;

  ep0_cmd_decode #(.W(CSR_W)) u_dec (
    .wr(cpu_wr), .wdata(cpu_wdata), .cmd(cmd)
  );

  ep0_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .lnk_rx_done(lnk_rx_done), .lnk_tx_done(lnk_tx_done),
    .lnk_stall_sent(lnk_stall_sent), .lnk_xfer_end(lnk_xfer_end),
    .q(flg), .irq_src(irq_src), .flush_src(flush_src)
  );

  ep0_pulse_out u_out (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .irq_src(irq_src),
    .flush_src(flush_src), .irq(irq), .fifo_flush(fifo_flush),
    .fifo_ptr_rst(fifo_ptr_rst)
  );

  always_comb begin
    cpu_rdata              = '0;
    cpu_rdata[B_STALL]     = flg.stall;
    cpu_rdata[B_SETUPEND]  = flg.setupend;
    cpu_rdata[B_DATAEND]   = flg.dataend;
    cpu_rdata[B_SENTSTALL] = flg.sentstall;
    cpu_rdata[B_TXRDY]     = flg.txrdy;
    cpu_rdata[B_RXRDY]     = flg.rxrdy;
    stall_req              = flg.stall;
    tx_ready               = flg.txrdy;
  end

  // R2
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> !tx_ready);
  // R3
  flush_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wdata[B_FLUSH] && !cpu_rdata[B_TXRDY] && !cpu_rdata[B_RXRDY]
     && !lnk_xfer_end) |=> !fifo_flush);
  // R1
  cmd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[CSR_W-1:B_SVC_RX] == '0);
  // R5
  stall_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_req) |-> $past(lnk_stall_sent));
endmodule

// File: tb/sim_ep0_ctl_status.sv
module sim_ep0_ctl_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        irq_en = 1'b1;
  logic        rx_d = 1'b0, tx_d = 1'b0, st_d = 1'b0, xe_d = 1'b0;
  logic        stall_req, tx_ready, fifo_flush, fifo_ptr_rst, irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ep0_ctl_status u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_en(irq_en), .lnk_rx_done(rx_d),
    .lnk_tx_done(tx_d), .lnk_stall_sent(st_d), .lnk_xfer_end(xe_d),
    .stall_req(stall_req), .tx_ready(tx_ready), .fifo_flush(fifo_flush),
    .fifo_ptr_rst(fifo_ptr_rst), .irq(irq)
  );

  // behavioural reference
  bit m_rx, m_tx, m_de, m_se, m_ss, m_sst, m_irq, m_fl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_rx, m_tx, m_de, m_se, m_ss, m_sst, m_irq, m_fl} = '0;
    end else begin
      bit any_ready, discard, early_end, sent_pkt;
      bit n_rx, n_tx, n_de, n_se, n_ss, n_sst;
      any_ready = m_rx || m_tx;
      discard   = cpu_wr && cpu_wdata[8] && any_ready;
      early_end = xe_d && !m_de;
      sent_pkt  = tx_d && m_tx;
      n_rx  = rx_d ? 1'b1 : ((cpu_wr && cpu_wdata[6]) || discard || early_end) ? 1'b0 : m_rx;
      n_tx  = (sent_pkt || discard || early_end) ? 1'b0 : (cpu_wr && cpu_wdata[1]) ? 1'b1 : m_tx;
      n_de  = xe_d ? 1'b0 : (cpu_wr && cpu_wdata[3]) ? 1'b1 : m_de;
      n_se  = early_end ? 1'b1 : (cpu_wr && cpu_wdata[7]) ? 1'b0 : m_se;
      n_ss  = st_d ? 1'b0 : (cpu_wr && cpu_wdata[5]) ? 1'b1 : m_ss;
      n_sst = st_d ? 1'b1 : (cpu_wr && cpu_wdata[2]) ? 1'b0 : m_sst;
      m_irq = irq_en && (rx_d || sent_pkt || early_end);
      m_fl  = discard || early_end;
      {m_rx, m_tx, m_de, m_se, m_ss, m_sst} = {n_rx, n_tx, n_de, n_se, n_ss, n_sst};
    end
  end

  function automatic string tag_of_bit(int b);
    case (b)
      0: return "R10";
      1: return "R9";
      2: return "R6";
      3: return "R8";
      4: return "R7";
      5: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] exp_rd;
      exp_rd = {10'b0, m_ss, m_se, m_de, m_sst, m_tx, m_rx};
      if (cpu_rdata !== exp_rd) begin
        for (int b = 0; b < 16; b++)
          if (cpu_rdata[b] !== exp_rd[b]) begin
            check(tag_of_bit(b), "rdata", cpu_rdata, exp_rd);
            break;
          end
      end else checks++;
      check("R11", "irq", {15'b0, irq}, {15'b0, m_irq});
      check("R2", "fifo_flush", {15'b0, fifo_flush}, {15'b0, m_fl});
      check("R2", "fifo_ptr_rst", {15'b0, fifo_ptr_rst}, {15'b0, m_fl});
      check("R5", "stall_req", {15'b0, stall_req}, {15'b0, m_ss});
      check("R9", "tx_ready", {15'b0, tx_ready}, {15'b0, m_tx});
    end
  end

  task automatic idle();
    cpu_wr = 0; cpu_wdata = '0; rx_d = 0; tx_d = 0; st_d = 0; xe_d = 0;
  endtask

  // one cycle of stimulus, driven at a falling edge
  task automatic step(bit wr, logic [15:0] wd, bit rx, bit tx, bit st, bit xe);
    cpu_wr = wr; cpu_wdata = wd; rx_d = rx; tx_d = tx; st_d = st; xe_d = xe;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 50000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "reset rdata", cpu_rdata, 16'h0000);
    check("R1", "reset outs", {11'b0, stall_req, tx_ready, fifo_flush, fifo_ptr_rst, irq}, 16'h0);
    @(negedge clk);

    // R3 flush with nothing pending
    step(1, 16'h0100, 0, 0, 0, 0);
    check("R3", "flush idle rdata", cpu_rdata, 16'h0000);
    check("R3", "flush idle pulse", {15'b0, fifo_flush}, 16'h0);

    // R10 rx arrival, R4 service clears it
    step(0, 16'h0, 1, 0, 0, 0);
    check("R10", "rx set", cpu_rdata, 16'h0001);
    check("R11", "rx irq", {15'b0, irq}, 16'h1);
    step(1, 16'h0001, 0, 0, 0, 0);
    check("R10", "rx not writable", cpu_rdata, 16'h0001);
    step(1, 16'h0040, 0, 0, 0, 0);
    check("R4", "svc rx clears", cpu_rdata, 16'h0000);

    // R12 rx arrival beats same-cycle service
    step(1, 16'h0040, 1, 0, 0, 0);
    check("R12", "rx wins svc", cpu_rdata, 16'h0001);
    // R2 flush with rx pending
    step(1, 16'h0100, 0, 0, 0, 0);
    check("R2", "flush clears", cpu_rdata, 16'h0000);
    check("R2", "flush pulse", {14'b0, fifo_flush, fifo_ptr_rst}, 16'h3);

    // R9 tx load and send, R8 data-end
    step(1, 16'h000A, 0, 0, 0, 0);
    check("R9", "tx+dataend set", cpu_rdata, 16'h000A);
    step(0, 16'h0, 0, 1, 0, 0);
    check("R9", "tx done", cpu_rdata, 16'h0008);
    check("R11", "tx irq", {15'b0, irq}, 16'h1);
    step(0, 16'h0, 0, 1, 0, 0);
    check("R11", "tx done idle no irq", {15'b0, irq}, 16'h0);
    step(0, 16'h0, 0, 0, 0, 1);
    check("R7", "normal end", cpu_rdata, 16'h0000);
    check("R7", "normal end no flush", {15'b0, fifo_flush}, 16'h0);

    // R7 early end with tx pending
    step(1, 16'h0002, 0, 0, 0, 0);
    step(0, 16'h0, 0, 0, 0, 1);
    check("R7", "early end", cpu_rdata, 16'h0010);
    check("R7", "early end flush", {15'b0, fifo_flush}, 16'h1);
    step(1, 16'h0080, 0, 0, 0, 0);
    check("R4", "svc setup clears", cpu_rdata, 16'h0000);

    // R5 stall, R6 sent-stall
    step(1, 16'h0020, 0, 0, 0, 0);
    step(0, 16'h0, 0, 0, 0, 0);
    check("R5", "stall held", {15'b0, stall_req}, 16'h1);
    step(0, 16'h0, 0, 0, 1, 0);
    check("R5", "stall released", cpu_rdata, 16'h0004);
    step(1, 16'h0000, 0, 0, 0, 0);
    check("R6", "write 0 keeps", cpu_rdata, 16'h0004);
    step(1, 16'h0004, 0, 0, 1, 0);
    check("R12", "sent beats clear", cpu_rdata, 16'h0004);
    step(1, 16'h0004, 0, 0, 0, 0);
    check("R6", "w1 clears", cpu_rdata, 16'h0000);

    // R11 gated interrupt
    irq_en = 0;
    step(0, 16'h0, 1, 0, 0, 0);
    check("R11", "gated irq", {15'b0, irq}, 16'h0);
    irq_en = 1;
    step(1, 16'h0040, 0, 0, 0, 0);

    // mixed stimulus compared every cycle
    for (int i = 0; i < 4000; i++) begin
      irq_en = ($urandom_range(3) != 0);
      step(($urandom_range(3) == 0), 16'($urandom),
           ($urandom_range(7) == 0), ($urandom_range(5) == 0),
           ($urandom_range(9) == 0), ($urandom_range(9) == 0));
    end
    done = 1;
    finish_run();
  end
endmodule